// File: doc/BRIEF.md
# Multiprocessor 9-bit UART receiver

This block is the receive half of an asynchronous serial port meant for a shared line with one master and several slaves. It watches the line for a start bit and confirms the start bit at its midpoint. Each following bit is sampled at its centre using a 16x oversampling tick, and the frame ends on its stop bit. Two frame lengths are supported. An 8-bit frame carries eight data bits. A 9-bit frame carries a ninth bit, which tags the frame as an address (1) or as data (0).

A multiprocessor-enable input, `mp_en`, decides whether a finished frame raises the receive interrupt. In 9-bit mode with parity disabled, a set `mp_en` passes only address frames. An unaddressed slave therefore never sees the data meant for another node. The addressed slave clears `mp_en` in software and then takes every frame. In the stop-checked 8-bit mode, the same input makes the interrupt depend on a valid stop bit. In the plain 8-bit mode it has no effect.

The received byte and the captured ninth bit change only on frames that raise the interrupt. The interrupt flag stays set until it is cleared through a dedicated input. A framing-error flag reports a bad stop bit on every frame, whatever the gating decided.

Top module: `mp_uart_rx`

## Requirements
- R1: After synchronous reset, `rx_irq`, `rx_ferr`, `rx_rb8` and `rx_data` are all 0.
- R2: A frame is: a low start bit, then the data bits LSB first, then (when `frm_mode` is 2 or 3) a ninth bit, then a stop bit. Each bit lasts 16 `tick16` pulses. `frm_mode` encodes 0 = plain 8-bit, 1 = stop-checked 8-bit, 2 and 3 = 9-bit. A frame that raises the interrupt shows its eight data bits on `rx_data`.
- R3: A low pulse on `rxd` that has gone high again by the start bit's midpoint (8 ticks) is ignored: no interrupt, and no output changes.
- R4: In 9-bit mode with `par_off`=1 and `mp_en`=1, a frame whose ninth bit is 0 raises no interrupt, and a frame whose ninth bit is 1 raises it.
- R5: In 9-bit mode with `par_off`=0, every frame raises the interrupt whatever its ninth bit.
- R6: In mode 1 with `mp_en`=1, the interrupt is raised only when the stop bit is sampled as 1.
- R7: In mode 0, `mp_en` has no effect: every frame raises the interrupt.
- R8: With `mp_en`=0, every frame raises the interrupt in every mode, whatever its ninth or stop bit.
- R9: `rx_data` and `rx_rb8` are updated only by frames that raise the interrupt. `rx_rb8` takes the ninth bit in 9-bit mode and the stop bit in the 8-bit modes.
- R10: `rx_irq` stays set until `irq_clr` is pulsed. A frame that raises the interrupt in the same cycle as a clear wins.
- R11: After every completed frame, in any mode and whether or not it raised the interrupt, `rx_ferr` equals the inverse of that frame's stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idles high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| frm_mode | input | 2 | 0 plain 8-bit, 1 stop-checked 8-bit, 2/3 9-bit |
| mp_en | input | 1 | Multiprocessor interrupt gating enable |
| par_off | input | 1 | 1 = ninth bit is an address tag, 0 = ninth bit is parity |
| irq_clr | input | 1 | Clears the receive interrupt flag |
| rx_data | output | 8 | Last accepted data byte |
| rx_rb8 | output | 1 | Ninth bit (9-bit mode) or stop bit (8-bit modes) of the last accepted frame |
| rx_irq | output | 1 | Sticky receive interrupt flag |
| rx_ferr | output | 1 | Stop bit of the last completed frame was 0 |

## Verification
The properties assume that `frm_mode`, `mp_en` and `par_off` stay constant from a start bit until its frame completes, and that `tick16` comes at a steady rate. The gating decision is read at the frame's last cycle, so controls that changed in the middle of a frame would break the mode-dependent checks. The stimulus changes these controls only while the line idles between frames. Each frame is followed by two idle bit times, so a bad stop bit cannot run into the next start bit.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN8 = 2'd0,
    MODE_CHK8   = 2'd1,
    MODE_NINE   = 2'd2,
    MODE_NINE_B = 2'd3
  } mpu_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } mpu_state_e;
endpackage

// File: rtl/mpu_sync.sv
module mpu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpu_bitsampler.sv
module mpu_bitsampler
  import mpu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              nine_mode,
  output logic              frm_done,
  output logic [DATA_W-1:0] frm_byte,
  output logic              frm_ninth,
  output logic              frm_stop
);
  localparam int CNT_W   = $clog2(OVERSAMPLE);
  localparam int BCNT_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BCNT_W-1:0] NB8 = BCNT_W'(DATA_W);
  localparam logic [BCNT_W-1:0] NB9 = BCNT_W'(DATA_W + 1);

  mpu_state_e        state;
  logic [CNT_W-1:0]  tcnt;
  logic [BCNT_W-1:0] bcnt;
  logic [DATA_W:0]   shreg;
  logic              nine_q;
  logic [BCNT_W-1:0] nbits;

  assign nbits = nine_q ? NB9 : NB8;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      bcnt      <= '0;
      shreg     <= '0;
      nine_q    <= 1'b0;
      frm_done  <= 1'b0;
      frm_byte  <= '0;
      frm_ninth <= 1'b0;
      frm_stop  <= 1'b1;
    end else begin
      frm_done <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            tcnt <= '0;
            if (!line) begin
              state  <= ST_START;
              nine_q <= nine_mode;
            end
          end
          ST_START: begin
            if (tcnt == MID_LAST) begin
              tcnt <= '0;
              bcnt <= '0;
              state <= line ? ST_IDLE : ST_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (tcnt == BIT_LAST) begin
              tcnt  <= '0;
              shreg <= {line, shreg[DATA_W:1]};
              bcnt  <= bcnt + 1'b1;
              if (bcnt == nbits - 1'b1) state <= ST_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (tcnt == BIT_LAST) begin
              tcnt     <= '0;
              state    <= ST_IDLE;
              frm_done <= 1'b1;
              frm_stop <= line;
              if (nine_q) begin
                frm_byte  <= shreg[DATA_W-1:0];
                frm_ninth <= shreg[DATA_W];
              end else begin
                frm_byte  <= shreg[DATA_W:1];
                frm_ninth <= 1'b0;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpu_irqgate.sv
module mpu_irqgate
  import mpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] frm_byte,
  input  logic              frm_ninth,
  input  logic              frm_stop,
  input  logic [1:0]        mode,
  input  logic              mp_en,
  input  logic              par_off,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rb8,
  output logic              rx_irq,
  output logic              rx_ferr
);
  logic nine_mode;
  logic fire;

  assign nine_mode = mode[1];

  always_comb begin
    fire = 1'b1;
    if (mp_en) begin
      if (mode == MODE_CHK8)          fire = frm_stop;
      else if (nine_mode && par_off)  fire = frm_ninth;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_rb8  <= 1'b0;
      rx_irq  <= 1'b0;
      rx_ferr <= 1'b0;
    end else begin
      if (irq_clr) rx_irq <= 1'b0;
      if (frm_done) begin
        rx_ferr <= ~frm_stop;
        if (fire) begin
          rx_irq  <= 1'b1;
          rx_data <= frm_byte;
          rx_rb8  <= nine_mode ? frm_ninth : frm_stop;
        end
      end
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              tick16,
  input  logic [1:0]        frm_mode,
  input  logic              mp_en,
  input  logic              par_off,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rb8,
  output logic              rx_irq,
  output logic              rx_ferr
);
  logic              line_s;
  logic              frm_done;
  logic [DATA_W-1:0] frm_byte;
  logic              frm_ninth;
  logic              frm_stop;

  mpu_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  mpu_bitsampler #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) samp_i (
    .clk(clk), .rst(rst), .tick(tick16), .line(line_s),
    .nine_mode(frm_mode[1]),
    .frm_done(frm_done), .frm_byte(frm_byte),
    .frm_ninth(frm_ninth), .frm_stop(frm_stop)
  );

  mpu_irqgate #(.DATA_W(DATA_W)) gate_i (
    .clk(clk), .rst(rst),
    .frm_done(frm_done), .frm_byte(frm_byte),
    .frm_ninth(frm_ninth), .frm_stop(frm_stop),
    .mode(frm_mode), .mp_en(mp_en), .par_off(par_off), .irq_clr(irq_clr),
    .rx_data(rx_data), .rx_rb8(rx_rb8), .rx_irq(rx_irq), .rx_ferr(rx_ferr)
  );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        frm_mode,
  input logic              mp_en,
  input logic              par_off,
  input logic              irq_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_rb8,
  input logic              rx_irq,
  input logic              rx_ferr,
  input logic              frm_done,
  input logic              frm_ninth,
  input logic              frm_stop
);
  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && !irq_clr) |=> rx_irq);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !frm_done) |=> !rx_irq);

  assert_data_frame_held_R4: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mp_en && frm_mode[1] && par_off && !frm_ninth && !rx_irq) |=> !rx_irq);

  assert_addr_frame_irq_R4: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mp_en && frm_mode[1] && par_off && frm_ninth) |=> rx_irq);

  assert_bad_stop_held_R6: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mp_en && frm_mode == 2'd1 && !frm_stop && !rx_irq) |=> !rx_irq);

  assert_gate_off_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (frm_done && !mp_en) |=> rx_irq);

  assert_plain_mode_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (frm_done && frm_mode == 2'd0) |=> rx_irq);

  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !frm_done |=> ($stable(rx_data) && $stable(rx_rb8)));

  assert_ferr_tracks_R11: assert property (@(posedge clk) disable iff (rst)
    frm_done |=> (rx_ferr == !$past(frm_stop)));
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .frm_mode(frm_mode), .mp_en(mp_en),
  .par_off(par_off), .irq_clr(irq_clr), .rx_data(rx_data),
  .rx_rb8(rx_rb8), .rx_irq(rx_irq), .rx_ferr(rx_ferr),
  .frm_done(frm_done), .frm_ninth(frm_ninth), .frm_stop(frm_stop)
);

// File: tb/mp_uart_rx_tb_top.sv
`timescale 1ns/1ps
module mp_uart_rx_tb_top;
  localparam int BITCLK = 32;
  localparam int NVEC   = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       tick16 = 1'b0;
  logic [1:0] frm_mode = 2'd0;
  logic       mp_en = 1'b0;
  logic       par_off = 1'b1;
  logic       irq_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_rb8, rx_irq, rx_ferr;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] exp_data = 8'h00;
  logic       exp_rb8  = 1'b0;

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk) tick16 = ~tick16;
  end

  mp_uart_rx dut_i (
    .clk(clk), .rst(rst), .rxd(rxd), .tick16(tick16), .frm_mode(frm_mode),
    .mp_en(mp_en), .par_off(par_off), .irq_clr(irq_clr),
    .rx_data(rx_data), .rx_rb8(rx_rb8), .rx_irq(rx_irq), .rx_ferr(rx_ferr)
  );

  // {mode[1:0], mp_en, par_off, bits[8:0], stop, exp_irq, exp_ferr}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd2, 1'b0, 1'b1, 9'h0A5, 1'b1, 1'b1, 1'b0},  // R8
    {2'd2, 1'b1, 1'b1, 9'h0C3, 1'b1, 1'b0, 1'b0},  // R4 data held
    {2'd2, 1'b1, 1'b1, 9'h13C, 1'b1, 1'b1, 1'b0},  // R4 address
    {2'd2, 1'b1, 1'b0, 9'h055, 1'b1, 1'b1, 1'b0},  // R5
    {2'd1, 1'b1, 1'b1, 9'h05A, 1'b1, 1'b1, 1'b0},  // R6 good stop
    {2'd1, 1'b1, 1'b1, 9'h0E7, 1'b0, 1'b0, 1'b1},  // R6 bad stop, R11
    {2'd1, 1'b0, 1'b1, 9'h024, 1'b0, 1'b1, 1'b1},  // R8, R11
    {2'd0, 1'b1, 1'b1, 9'h099, 1'b0, 1'b1, 1'b1},  // R7
    {2'd0, 1'b1, 1'b1, 9'h081, 1'b1, 1'b1, 1'b0},  // R7
    {2'd2, 1'b1, 1'b1, 9'h16E, 1'b0, 1'b1, 1'b1},  // R4, R11
    {2'd3, 1'b1, 1'b1, 9'h1F0, 1'b1, 1'b1, 1'b0},  // R2 mode 3
    {2'd3, 1'b1, 1'b1, 9'h00F, 1'b1, 1'b0, 1'b0}   // R4 mode 3 data held
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic nine, input logic [8:0] bits, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(bits[i]);
    if (nine) send_bit(bits[8]);
    send_bit(stop);
    rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq", {8'h0, rx_irq}, 9'h0);
    check("R1 ferr", {8'h0, rx_ferr}, 9'h0);
    check("R1 rb8", {8'h0, rx_rb8}, 9'h0);
    check("R1 data", {1'b0, rx_data}, 9'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] e;
      e = VEC[v];
      frm_mode = e[15:14];
      mp_en    = e[13];
      par_off  = e[12];
      pulse_clr();
      send_frame(e[15], e[11:3], e[2]);
      if (e[1]) begin
        exp_data = e[10:3];
        exp_rb8  = e[15] ? e[11] : e[2];
      end
      check($sformatf("R4/R5/R6/R7/R8 irq vec%0d", v), {8'h0, rx_irq}, {8'h0, e[1]});
      check($sformatf("R11 ferr vec%0d", v), {8'h0, rx_ferr}, {8'h0, e[0]});
      check($sformatf("R2/R9 data vec%0d", v), {1'b0, rx_data}, {1'b0, exp_data});
      check($sformatf("R9 rb8 vec%0d", v), {8'h0, rx_rb8}, {8'h0, exp_rb8});
    end

    // R10: flag holds with no clear, then clears
    frm_mode = 2'd0; mp_en = 1'b0;
    pulse_clr();
    send_frame(1'b0, 9'h03C, 1'b1);
    repeat (200) @(negedge clk);
    check("R10 irq held", {8'h0, rx_irq}, 9'h1);
    pulse_clr();
    check("R10 irq cleared", {8'h0, rx_irq}, 9'h0);
    check("R2 data 3C", {1'b0, rx_data}, 9'h03C);

    // R3: short low pulse is not a start bit
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (20 * BITCLK) @(negedge clk);
    check("R3 glitch irq", {8'h0, rx_irq}, 9'h0);
    check("R3 glitch data", {1'b0, rx_data}, 9'h03C);
    check("R3 glitch ferr", {8'h0, rx_ferr}, 9'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule